// File: doc/BRIEF.md
# UART Receive Queue with Level-Tracking Interrupt

This block is the host-side receive queue of one UART channel. The receive shift register hands each finished character over with a one-cycle write strobe. The host takes characters out by reading the receive holding register. A ring buffer of sixteen bytes sits between the two. An occupancy counter drives three registered flags: a data-ready bit for the line status register, a trigger-level bit for the interrupt status register, and the receive interrupt line.

The interrupt does not latch. It rises when the fill count reaches the level chosen by a two-bit select, and it drops by itself once reads take the count below that level. No acknowledge is needed. When queue mode is switched off, the block acts as a one-byte holding register, and every flag then follows whether that byte is occupied. A clear input empties the queue in a single cycle.

Top module: `rxq_rx_fifo`

## Requirements
- R1: In queue mode (`fifo_en`=1) up to 16 characters are stored, and reads return them in the order they were written.
- R2: `data_rdy` is 1 exactly when the stored count was nonzero at the previous clock edge. It goes high after the first character arrives and drops only when the queue is empty.
- R3: `trig_sel` picks the trigger level: 0 gives 1 character, 1 gives 4, 2 gives 8 and 3 gives 14. In queue mode `trig_stat` is 1 when the count at the previous edge was at or above that level.
- R4: `rx_irq` equals the `trig_stat` condition ANDed with `rx_int_en`. It stays 0 while `rx_int_en` is 0, and it falls without any acknowledge once the count drops below the level.
- R5: With `fifo_en`=0 the capacity is one byte. A second write is dropped with an overrun, the first byte is kept, and `data_rdy`, `trig_stat` and `rx_irq` follow whether the byte is occupied.
- R6: A write that finds the queue full, with no read in the same cycle, is discarded. `overrun` is then 1 for the one cycle after that clock edge.
- R7: A read of an empty queue leaves `rd_data` and the count unchanged.
- R8: A read and a write in the same cycle on a non-empty queue leave the count unchanged. This also holds when the queue is full.
- R9: `clr` empties the queue at its clock edge and zeroes `data_rdy`, `trig_stat`, `rx_irq` and `overrun` at that same edge. Bytes stored before the clear are never returned.
- R10: A read of a non-empty queue puts the oldest byte on `rd_data` right after that clock edge. `rd_data` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous queue clear |
| fifo_en | input | 1 | 1 selects the 16-entry queue, 0 selects the one-byte holding mode |
| rx_int_en | input | 1 | Receive interrupt enable |
| trig_sel | input | 2 | Trigger level select (1/4/8/14) |
| wr_stb | input | 1 | Character write strobe from the shift register |
| wr_data | input | 8 | Character being written |
| rd_stb | input | 1 | Host read strobe for the holding register |
| rd_data | output | 8 | Last character read |
| data_rdy | output | 1 | Line-status data-ready bit |
| trig_stat | output | 1 | Interrupt-status trigger-level bit |
| rx_irq | output | 1 | Receive interrupt |
| overrun | output | 1 | One-cycle pulse for a dropped write |

## Verification
The results have two different latencies. The count, `rd_data` and `overrun` change at the edge that samples the strobe. `data_rdy`, `trig_stat` and `rx_irq` appear one edge later, computed from the count held before that edge and from the enables and select sampled at it. The exception is `clr`, which zeroes all flags at its own edge. The bench reproduces this timing: for each step it computes the flag values from its model's count before updating the model, and it checks every output one nanosecond after the edge.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   localparam int unsigned RXQ_NLVL = 4;

   typedef int unsigned lvl_tab_t [RXQ_NLVL];

   // fill levels selected by trig_sel = 0,1,2,3
   localparam lvl_tab_t RXQ_LVL_DFLT = '{1, 4, 8, 14};

   typedef struct packed {
      logic rdy;
      logic trig;
      logic irq;
      logic ovr;
   } rxq_flag_t;

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter  int unsigned DEPTH = 16,
   parameter  int unsigned DW    = 8,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic          pop,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout
);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp;
   logic [AW-1:0] rp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp   <= '0;
         rp   <= '0;
         dout <= '0;
      end else if (clr) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop) begin
            rp   <= rp + 1'b1;
            dout <= mem[rp];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (push && !clr) mem[wp] <= din;
   end

endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
   parameter  int unsigned DEPTH = 16,
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          fifo_en,
   input  logic          wr_stb,
   input  logic          rd_stb,
   output logic          push,
   output logic          pop,
   output logic          drop,
   output logic [CW-1:0] cnt
);

   logic full;

   always_comb begin
      pop  = rd_stb && (cnt != '0);
      full = fifo_en ? (cnt >= CW'(DEPTH)) : (cnt != '0);
      // a write into a full queue still fits when a read frees a slot
      push = wr_stb && (!full || pop);
      drop = wr_stb && !push;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else begin
         unique case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
   import rxq_pkg::*;
#(
   parameter  int unsigned DEPTH = 16,
   parameter  lvl_tab_t    LVL   = RXQ_LVL_DFLT,
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          fifo_en,
   input  logic          rx_int_en,
   input  logic [1:0]    trig_sel,
   input  logic          drop,
   input  logic [CW-1:0] cnt,
   output rxq_flag_t     flags
);

   logic [RXQ_NLVL-1:0] hit_vec;
   logic                lvl_hit;

   for (genvar i = 0; i < RXQ_NLVL; i++) begin : g_cmp
      assign hit_vec[i] = (cnt >= CW'(LVL[i]));
   end

   assign lvl_hit = fifo_en ? hit_vec[trig_sel] : (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
      end else if (clr) begin
         flags <= '0;
      end else begin
         flags.rdy  <= (cnt != '0);
         flags.trig <= lvl_hit;
         flags.irq  <= lvl_hit && rx_int_en;
         flags.ovr  <= drop;
      end
   end

endmodule

// File: rtl/rxq_rx_fifo.sv
module rxq_rx_fifo
   import rxq_pkg::*;
#(
   parameter  int unsigned DEPTH = 16,
   parameter  int unsigned DW    = 8,
   parameter  lvl_tab_t    LVL   = RXQ_LVL_DFLT,
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          fifo_en,
   input  logic          rx_int_en,
   input  logic [1:0]    trig_sel,
   input  logic          wr_stb,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_stb,
   output logic [DW-1:0] rd_data,
   output logic          data_rdy,
   output logic          trig_stat,
   output logic          rx_irq,
   output logic          overrun
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rxq_rx_fifo: DEPTH must be a power of two and at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("rxq_rx_fifo: DW must be at least 1");
   end
   for (genvar i = 0; i < RXQ_NLVL; i++) begin : g_lvl_chk
      if (LVL[i] < 1 || LVL[i] > DEPTH) begin : g_bad_lvl
         $error("rxq_rx_fifo: trigger level out of range");
      end
   end

   logic          push;
   logic          pop;
   logic          drop;
   logic [CW-1:0] cnt;
   rxq_flag_t     flags;

   rxq_level #(.DEPTH(DEPTH)) u_level (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .fifo_en (fifo_en),
      .wr_stb  (wr_stb),
      .rd_stb  (rd_stb),
      .push    (push),
      .pop     (pop),
      .drop    (drop),
      .cnt     (cnt)
   );

   rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .push  (push),
      .pop   (pop),
      .din   (wr_data),
      .dout  (rd_data)
   );

   rxq_flags #(.DEPTH(DEPTH), .LVL(LVL)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .fifo_en   (fifo_en),
      .rx_int_en (rx_int_en),
      .trig_sel  (trig_sel),
      .drop      (drop),
      .cnt       (cnt),
      .flags     (flags)
   );

   assign data_rdy  = flags.rdy;
   assign trig_stat = flags.trig;
   assign rx_irq    = flags.irq;
   assign overrun   = flags.ovr;

endmodule

// File: rtl/rxq_rx_fifo_chk.sv
module rxq_rx_fifo_chk #(
   parameter  int unsigned DEPTH = 16,
   parameter  int unsigned DW    = 8,
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          clr,
   input logic          fifo_en,
   input logic          rx_int_en,
   input logic          wr_stb,
   input logic          rd_stb,
   input logic [DW-1:0] rd_data,
   input logic          data_rdy,
   input logic          trig_stat,
   input logic          rx_irq,
   input logic          overrun,
   input logic [CW-1:0] cnt
);

   p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

   p_rdy_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (data_rdy == ($past(cnt) != '0)));

   p_irq_needs_stat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> trig_stat);

   p_irq_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_int_en |=> !rx_irq);

   p_single_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && wr_stb && !rd_stb && !clr && cnt == CW'(1)) |=> (overrun && cnt == CW'(1)));

   p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && wr_stb && !rd_stb && !clr && cnt == CW'(DEPTH)) |=> (overrun && $stable(cnt)));

   p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !wr_stb && !clr && cnt == '0) |=> ($stable(rd_data) && cnt == '0));

   p_rw_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && rd_stb && !clr && cnt != '0) |=> $stable(cnt));

   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0 && !data_rdy && !trig_stat && !rx_irq && !overrun));

endmodule

bind rxq_rx_fifo rxq_rx_fifo_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr       (clr),
   .fifo_en   (fifo_en),
   .rx_int_en (rx_int_en),
   .wr_stb    (wr_stb),
   .rd_stb    (rd_stb),
   .rd_data   (rd_data),
   .data_rdy  (data_rdy),
   .trig_stat (trig_stat),
   .rx_irq    (rx_irq),
   .overrun   (overrun),
   .cnt       (cnt)
);

// File: tb/test_rxq_rx_fifo.sv
`timescale 1ns/1ps
module test_rxq_rx_fifo;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr = 1'b0;
   logic       fifo_en = 1'b0;
   logic       rx_int_en = 1'b0;
   logic [1:0] trig_sel = 2'd0;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_data = 8'd0;
   logic       rd_stb = 1'b0;
   logic [7:0] rd_data;
   logic       data_rdy;
   logic       trig_stat;
   logic       rx_irq;
   logic       overrun;

   int         nchk = 0;
   int         nerr = 0;
   int         mcnt = 0;
   logic [7:0] last_rd = 8'd0;
   logic [7:0] mq [$];

   always #2 clk = ~clk;

   rxq_rx_fifo i_rxq_rx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .fifo_en   (fifo_en),
      .rx_int_en (rx_int_en),
      .trig_sel  (trig_sel),
      .wr_stb    (wr_stb),
      .wr_data   (wr_data),
      .rd_stb    (rd_stb),
      .rd_data   (rd_data),
      .data_rdy  (data_rdy),
      .trig_stat (trig_stat),
      .rx_irq    (rx_irq),
      .overrun   (overrun)
   );

   function automatic int lvl_of(input logic [1:0] s);
      case (s)
         2'd0:    return 1;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return 14;
      endcase
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // called at a negedge; drives one cycle, checks all outputs after the edge
   task automatic step(input bit w, input logic [7:0] d, input bit r, input bit c);
      bit         e_hit, e_rdy, e_trg, e_irq, e_ovr, m_pop, m_full, m_push;
      logic [7:0] e_rd;
      wr_stb  = w;
      wr_data = d;
      rd_stb  = r;
      clr     = c;
      e_hit  = fifo_en ? (mcnt >= lvl_of(trig_sel)) : (mcnt != 0);
      e_rdy  = !c && (mcnt != 0);
      e_trg  = !c && e_hit;
      e_irq  = !c && e_hit && rx_int_en;
      m_pop  = r && (mcnt > 0);
      m_full = fifo_en ? (mcnt >= 16) : (mcnt >= 1);
      m_push = w && (!m_full || m_pop);
      e_ovr  = !c && w && !m_push;
      e_rd   = last_rd;
      if (c) begin
         mq.delete();
      end else begin
         if (m_pop) e_rd = mq.pop_front();
         if (m_push) mq.push_back(d);
      end
      mcnt    = mq.size();
      last_rd = e_rd;
      @(posedge clk);
      #1;
      check("R2 data ready", int'(data_rdy), int'(e_rdy));
      check("R3 trigger status", int'(trig_stat), int'(e_trg));
      check("R4 interrupt", int'(rx_irq), int'(e_irq));
      check("R6 overrun", int'(overrun), int'(e_ovr));
      check("R10 read data", int'(rd_data), int'(e_rd));
      @(negedge clk);
   endtask

   task automatic idle();
      step(1'b0, 8'h00, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R10 reset rd_data", int'(rd_data), 0);
      check("R2 reset data_rdy", int'(data_rdy), 0);
      check("R4 reset irq", int'(rx_irq), 0);
      check("R6 reset overrun", int'(overrun), 0);
      @(negedge clk);

      // R1 fill 16 at level 14
      fifo_en = 1'b1; rx_int_en = 1'b1; trig_sel = 2'd3;
      for (int i = 0; i < 16; i++) step(1'b1, 8'(i * 7 + 3), 1'b0, 1'b0);
      idle();
      check("R3 level 14 reached", int'(trig_stat), 1);
      step(1'b1, 8'hEE, 1'b0, 1'b0);
      check("R6 write to full", int'(overrun), 1);
      step(1'b1, 8'h55, 1'b1, 1'b0);
      check("R8 read+write at full", int'(overrun), 0);
      step(1'b1, 8'h66, 1'b0, 1'b0);
      check("R8 count stayed at 16", int'(overrun), 1);
      for (int i = 0; i < 16; i++) step(1'b0, 8'h00, 1'b1, 1'b0);
      idle();
      check("R2 empty clears ready", int'(data_rdy), 0);
      check("R4 irq fell below level", int'(rx_irq), 0);

      // R7 empty read
      step(1'b0, 8'h00, 1'b1, 1'b0);
      check("R7 empty read keeps data", int'(rd_data), 16'h55);
      idle();
      check("R7 count still zero", int'(data_rdy), 0);

      // R5 holding mode
      fifo_en = 1'b0;
      step(1'b1, 8'hA1, 1'b0, 1'b0);
      step(1'b1, 8'hB2, 1'b0, 1'b0);
      check("R5 second byte dropped", int'(overrun), 1);
      check("R5 trigger follows occupancy", int'(trig_stat), 1);
      step(1'b0, 8'h00, 1'b1, 1'b0);
      check("R5 first byte kept", int'(rd_data), 16'hA1);
      idle();
      check("R5 trigger clears when vacant", int'(trig_stat), 0);

      // R4 masking and self-clearing
      fifo_en = 1'b1; rx_int_en = 1'b0; trig_sel = 2'd0;
      step(1'b1, 8'h11, 1'b0, 1'b0);
      idle();
      check("R4 masked irq", int'(rx_irq), 0);
      rx_int_en = 1'b1;
      idle();
      check("R4 enabled irq", int'(rx_irq), 1);
      step(1'b0, 8'h00, 1'b1, 1'b0);
      idle();
      check("R4 irq falls by itself", int'(rx_irq), 0);

      // R9 clear
      trig_sel = 2'd2;
      for (int i = 0; i < 10; i++) step(1'b1, 8'(8'h40 + i), 1'b0, 1'b0);
      idle();
      check("R3 level 8 reached", int'(trig_stat), 1);
      step(1'b0, 8'h00, 1'b0, 1'b1);
      check("R9 clear zeroes ready", int'(data_rdy), 0);
      check("R9 clear zeroes irq", int'(rx_irq), 0);
      step(1'b0, 8'h00, 1'b1, 1'b0);
      check("R9 stored bytes discarded", int'(rd_data), 16'h11);

      // random mix
      for (int ph = 0; ph < 20; ph++) begin
         for (int k = 0; k < 200; k++) begin
            bit w, r, c;
            w = ($urandom % 100) < ((ph % 2 == 0) ? 75 : 30);
            r = ($urandom % 100) < ((ph % 2 == 0) ? 30 : 75);
            c = ($urandom % 1000) < 5;
            if (($urandom % 100) == 0) trig_sel = 2'($urandom);
            if (($urandom % 100) == 0) rx_int_en = ~rx_int_en;
            if (($urandom % 150) == 0) fifo_en = ~fifo_en;
            step(w, 8'($urandom), r, c);
         end
      end

      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

endmodule